// File: doc/BRIEF.md
# Four-channel SPI interrupt aggregator

This block holds the interrupt status and interrupt enable registers of a four-channel SPI controller and drives a single active-high interrupt request. Each channel reports two kinds of event as single-cycle pulses: its transmit buffer has emptied, and its receive buffer has filled. A pulse is recorded in the status register only when the channel's transfer mode and turbo setting allow it. Status bits are interleaved by channel with a stride of four. The transmit-empty bit sits at offset 0 of each group and the receive-full bit at offset 2. The remaining positions are reserved for events that only a self-test fill can set.

Software clears status bits by writing ones. It selects the bits that may raise the interrupt through the enable register. A system-test mode is made of two bits, a test-mode bit and a test-set bit, each written through its own strobe. When both are one, the block fills every implemented status bit and refuses software clears. Two resets return the whole block to its idle state: an asynchronous active-low reset, and a synchronous soft reset.

Top module: `spi_irq_agg`

## Requirements
- R1: A write to the enable register stores the write data ANDed with the implemented mask 0x1777f. Bits outside the mask always read as zero.
- R2: A transmit-empty pulse on channel n sets status bit 4n. A receive-full pulse on channel n sets status bit 4n+2. The bit is visible on the status readback one clock after the pulse.
- R3: A receive-full pulse is not recorded in either of two cases: the channel's 2-bit transfer mode (xfer_mode[2n+1:2n]) is 2'b10 (transmit-only), or the channel's turbo bit is one.
- R4: A transmit-empty pulse is not recorded when the channel's transfer mode is 2'b01 (receive-only). Modes 2'b00 and 2'b11 record both event kinds.
- R5: A status write clears every status bit where the write data holds a one, and leaves the other bits unchanged.
- R6: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: A status write has no effect while the stored test-mode bit and the stored test-set bit are both one.
- R8: In a cycle where a strobe writes a one to the test-mode bit or to the test-set bit, and both bits are one after that cycle, every status bit in 0x1777f is set.
- R9: The interrupt output is registered. It equals the OR over (status AND enable) as it stood one clock earlier.
- R10: The asynchronous reset and the soft reset each clear the status register, the enable register and both test bits. A soft reset overrides any write or event in the same cycle.
- R11: Status bits are sticky. Without a soft reset or an accepted clear, no set bit ever drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| tx_empty_ev | input | NUM_CH | Per-channel transmit-empty event pulses |
| rx_full_ev | input | NUM_CH | Per-channel receive-full event pulses |
| xfer_mode | input | 2*NUM_CH | Per-channel transfer mode: 01 receive-only, 10 transmit-only, 00/11 both |
| turbo_en | input | NUM_CH | Per-channel turbo setting; suppresses receive-full recording |
| sts_wr | input | 1 | Status register write strobe (write-one-to-clear) |
| sts_wdata | input | STAT_W | Status write data |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | STAT_W | Enable write data |
| test_mode_wr | input | 1 | Test-mode bit write strobe |
| test_mode_wdata | input | 1 | Test-mode bit write value |
| test_bit_wr | input | 1 | Test-set bit write strobe |
| test_bit_wdata | input | 1 | Test-set bit write value |
| sts_rd | output | STAT_W | Status register readback |
| en_rd | output | STAT_W | Enable register readback |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
Directed patterns come first. Simultaneous transmit-empty pulses on all channels show whether the stride-four placement is correct. Receive-full pulses with a different mode or turbo setting on each channel separate the two suppression rules from one another. A full clear issued in the same cycle as an event shows whether the event takes priority over the clear. Writing the two test bits in both orders, with a clear attempted in between, tells the fill from the clear lock. A long random run then mixes events, clears, enable writes, rare test-bit writes and soft resets. A reference model predicts status, enable and the one-clock interrupt lag in every cycle.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned CH_N       = 4;
  localparam int unsigned CH_STRIDE  = 4;
  localparam int unsigned TX_OFS     = 0;
  localparam int unsigned RX_OFS     = 2;
  localparam int unsigned EXTRA_BITS = 1;
  localparam int unsigned STAT_W     = CH_N * CH_STRIDE + EXTRA_BITS;
  localparam logic [31:0] IMPL_MASK_DEF = 32'h0001_777f;

  typedef enum logic [1:0] {
    XFER_BOTH   = 2'b00,
    XFER_RXONLY = 2'b01,
    XFER_TXONLY = 2'b10,
    XFER_RSVD   = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/spi_irq_evmap.sv
module spi_irq_evmap
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int STRIDE = 4,
  parameter int TXO    = 0,
  parameter int RXO    = 2,
  parameter int SW     = 17
) (
  input  logic [NUM_CH-1:0]   tx_ev_i,
  input  logic [NUM_CH-1:0]   rx_ev_i,
  input  logic [2*NUM_CH-1:0] mode_i,
  input  logic [NUM_CH-1:0]   turbo_i,
  output logic [SW-1:0]       ev_bits_o
);
  logic [NUM_CH-1:0] tx_ok;
  logic [NUM_CH-1:0] rx_ok;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    xfer_mode_e m;
    assign m        = xfer_mode_e'(mode_i[2*g +: 2]);
    assign tx_ok[g] = tx_ev_i[g] & (m != XFER_RXONLY);
    assign rx_ok[g] = rx_ev_i[g] & (m != XFER_TXONLY) & ~turbo_i[g];
  end

  always_comb begin
    ev_bits_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      ev_bits_o[c*STRIDE+TXO] = tx_ok[c];
      ev_bits_o[c*STRIDE+RXO] = rx_ok[c];
    end
  end
endmodule

// File: rtl/spi_irq_test.sv
module spi_irq_test (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic mode_we,
  input  logic mode_wd,
  input  logic tbit_we,
  input  logic tbit_wd,
  output logic force_set_o,
  output logic clr_block_o
);
  logic mode_q, mode_d, tbit_q, tbit_d, ld;

  always_comb begin
    ld     = soft_rst | mode_we | tbit_we;
    mode_d = soft_rst ? 1'b0 : (mode_we ? mode_wd : mode_q);
    tbit_d = soft_rst ? 1'b0 : (tbit_we ? tbit_wd : tbit_q);
    force_set_o = ((mode_we & mode_wd) | (tbit_we & tbit_wd)) & mode_d & tbit_d;
    clr_block_o = mode_q & tbit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      tbit_q <= 1'b0;
    end else if (ld) begin
      mode_q <= mode_d;
      tbit_q <= tbit_d;
    end
  end

  // R8: writing test mode as one with the test-set bit stored fills status
  p_fill_on_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wd && tbit_q && !soft_rst && !(tbit_we && !tbit_wd)) |-> force_set_o);
  // R10: soft reset returns the lock to open
  p_soft_unlock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !clr_block_o);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int          SW   = 17,
  parameter logic [31:0] MASK = 32'h0001_777f
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [SW-1:0] ev_bits,
  input  logic          sts_we,
  input  logic [SW-1:0] sts_wd,
  input  logic          clr_block,
  input  logic          force_set,
  output logic [SW-1:0] sts_q
);
  localparam logic [SW-1:0] M = MASK[SW-1:0];

  logic [SW-1:0] clr_v, sts_d;
  logic          ld;

  always_comb begin
    clr_v = (sts_we && !clr_block) ? sts_wd : '0;
    ld    = soft_rst | sts_we | (|ev_bits) | force_set;
    if (soft_rst) sts_d = '0;
    else sts_d = ((sts_q & ~clr_v) | ev_bits | (force_set ? M : '0)) & M;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sts_q <= '0;
    else if (ld) sts_q <= sts_d;
  end

  // R5: accepted clear drops written-one bits not re-set by an event
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && !clr_block && !soft_rst && !force_set) |=>
      ((sts_q & $past(sts_wd) & ~$past(ev_bits)) == '0));
  // R6: an event always lands even with a same-cycle clear
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_bits && !soft_rst) |=> ((sts_q & $past(ev_bits)) == $past(ev_bits)));
  // R7: a blocked write removes nothing
  p_clr_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && clr_block && !soft_rst) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  // R8: fill sets every implemented bit
  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_set && !soft_rst) |=> (sts_q == M));
  // R11: bits stay set without an accepted clear
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !(sts_we && !clr_block)) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int          NUM_CH     = 4,
  parameter int          STRIDE     = 4,
  parameter int          TXO        = 0,
  parameter int          RXO        = 2,
  parameter int          EXTRA      = 1,
  parameter logic [31:0] IMPL_MASK  = 32'h0001_777f,
  localparam int         STAT_W     = NUM_CH * STRIDE + EXTRA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [NUM_CH-1:0]   tx_empty_ev,
  input  logic [NUM_CH-1:0]   rx_full_ev,
  input  logic [2*NUM_CH-1:0] xfer_mode,
  input  logic [NUM_CH-1:0]   turbo_en,
  input  logic                sts_wr,
  input  logic [STAT_W-1:0]   sts_wdata,
  input  logic                en_wr,
  input  logic [STAT_W-1:0]   en_wdata,
  input  logic                test_mode_wr,
  input  logic                test_mode_wdata,
  input  logic                test_bit_wr,
  input  logic                test_bit_wdata,
  output logic [STAT_W-1:0]   sts_rd,
  output logic [STAT_W-1:0]   en_rd,
  output logic                irq
);
  localparam logic [STAT_W-1:0] M = IMPL_MASK[STAT_W-1:0];

  logic [STAT_W-1:0] ev_bits, en_q, en_d, sts_q;
  logic              force_set, clr_block, en_ld, irq_q, irq_d;

  spi_irq_evmap #(.NUM_CH(NUM_CH), .STRIDE(STRIDE), .TXO(TXO), .RXO(RXO), .SW(STAT_W)) u_evmap (
    .tx_ev_i(tx_empty_ev), .rx_ev_i(rx_full_ev), .mode_i(xfer_mode),
    .turbo_i(turbo_en), .ev_bits_o(ev_bits)
  );

  spi_irq_test u_test (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .mode_we(test_mode_wr), .mode_wd(test_mode_wdata),
    .tbit_we(test_bit_wr), .tbit_wd(test_bit_wdata),
    .force_set_o(force_set), .clr_block_o(clr_block)
  );

  spi_irq_status #(.SW(STAT_W), .MASK(IMPL_MASK)) u_status (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev_bits(ev_bits),
    .sts_we(sts_wr), .sts_wd(sts_wdata), .clr_block(clr_block),
    .force_set(force_set), .sts_q(sts_q)
  );

  always_comb begin
    en_ld = soft_rst | en_wr;
    en_d  = soft_rst ? '0 : (en_wdata & M);
    irq_d = |(sts_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ld) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign sts_rd = sts_q;
  assign en_rd  = en_q;
  assign irq    = irq_q;

  // R1: no enable bit outside the implemented mask
  p_en_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_rd & ~M) == '0));
  // R9: one-clock lag of the request
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_rd & en_rd)) |=> irq);
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_rd & en_rd)) |=> !irq);
  // R10: soft reset empties both registers
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sts_rd == '0 && en_rd == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: an allowed transmit-empty pulse lands at 4n
    p_tx_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty_ev[c] && xfer_mode[2*c +: 2] != XFER_RXONLY && !soft_rst)
        |=> sts_rd[c*STRIDE+TXO]);
    // R3: suppressed receive-full leaves a clear bit clear
    p_rx_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((turbo_en[c] || xfer_mode[2*c +: 2] == XFER_TXONLY) && !sts_rd[c*STRIDE+RXO] && !force_set)
        |=> !sts_rd[c*STRIDE+RXO]);
    // R4: suppressed transmit-empty leaves a clear bit clear
    p_tx_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_mode[2*c +: 2] == XFER_RXONLY && !sts_rd[c*STRIDE+TXO] && !force_set)
        |=> !sts_rd[c*STRIDE+TXO]);
  end
endmodule

// File: tb/sim_spi_irq_agg.sv
module sim_spi_irq_agg;
  import spi_irq_pkg::*;
  localparam int W = STAT_W;
  localparam logic [W-1:0] MK = IMPL_MASK_DEF[W-1:0];

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic [CH_N-1:0] tx_ev = '0, rx_ev = '0, turbo = '0;
  logic [2*CH_N-1:0] mode = '0;
  logic sts_wr = 1'b0, en_wr = 1'b0, tm_wr = 1'b0, tm_wd = 1'b0, tb_wr = 1'b0, tb_wd = 1'b0;
  logic [W-1:0] sts_wd = '0, en_wd = '0;
  logic [W-1:0] sts_rd, en_rd;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_sts = '0, m_en = '0;
  logic m_mode = 1'b0, m_tbit = 1'b0, m_irq = 1'b0;

  always #5 clk = ~clk;

  spi_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .tx_empty_ev(tx_ev), .rx_full_ev(rx_ev), .xfer_mode(mode), .turbo_en(turbo),
    .sts_wr(sts_wr), .sts_wdata(sts_wd), .en_wr(en_wr), .en_wdata(en_wd),
    .test_mode_wr(tm_wr), .test_mode_wdata(tm_wd),
    .test_bit_wr(tb_wr), .test_bit_wdata(tb_wd),
    .sts_rd(sts_rd), .en_rd(en_rd), .irq(irq)
  );

  function automatic logic [W-1:0] f_ev(logic [CH_N-1:0] t, logic [CH_N-1:0] r,
                                        logic [2*CH_N-1:0] md, logic [CH_N-1:0] tu);
    logic [W-1:0] v = '0;
    for (int c = 0; c < CH_N; c++) begin
      if (t[c] && md[2*c +: 2] != 2'b01) v[c*4] = 1'b1;
      if (r[c] && md[2*c +: 2] != 2'b10 && !tu[c]) v[c*4+2] = 1'b1;
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " status"}, sts_rd, m_sts);
    chk({tag, " enable"}, en_rd, m_en);
    chk({tag, " irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
  endtask

  // advance model with current inputs, then one clock; returns at negedge
  task automatic tick();
    logic nm, nt, frc, blk;
    logic [W-1:0] clr, nsts;
    m_irq = |(m_sts & m_en);
    if (soft_rst) begin
      m_sts = '0; m_en = '0; m_mode = 1'b0; m_tbit = 1'b0;
    end else begin
      nm  = tm_wr ? tm_wd : m_mode;
      nt  = tb_wr ? tb_wd : m_tbit;
      frc = ((tm_wr & tm_wd) | (tb_wr & tb_wd)) & nm & nt;
      blk = m_mode & m_tbit;
      clr = (sts_wr && !blk) ? sts_wd : '0;
      nsts = ((m_sts & ~clr) | f_ev(tx_ev, rx_ev, mode, turbo) | (frc ? MK : '0)) & MK;
      m_sts = nsts;
      if (en_wr) m_en = en_wd & MK;
      m_mode = nm; m_tbit = nt;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    soft_rst = 0; tx_ev = '0; rx_ev = '0; sts_wr = 0; en_wr = 0; tm_wr = 0; tb_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R10 async reset status", sts_rd, '0);
    chk("R10 async reset enable", en_rd, '0);
    chk("R10 async reset irq", {{(W-1){1'b0}}, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 enable mask
    en_wr = 1; en_wd = '1; tick(); idle();
    chk("R1 enable mask", en_rd, 17'h1777f);
    check_all("R1");

    // R2 transmit-empty map on every channel
    tx_ev = '1; mode = '0; tick(); idle();
    chk("R2 tx map", sts_rd, 17'h01111);
    chk("R9 irq still low one clock after event", {{(W-1){1'b0}}, irq}, '0);
    tick();
    chk("R9 irq high after lag", {{(W-1){1'b0}}, irq}, 17'h1);
    check_all("R2");

    // R5 clear
    sts_wr = 1; sts_wd = 17'h00011; tick(); idle();
    chk("R5 partial clear", sts_rd, 17'h01100);
    sts_wr = 1; sts_wd = '1; tick(); idle();
    chk("R5 full clear", sts_rd, '0);
    tick();
    chk("R9 irq low after clear", {{(W-1){1'b0}}, irq}, '0);

    // R3 receive-full filters: ch0 tx-only, ch1 turbo, ch2 both, ch3 rx-only
    mode = 8'b01_00_00_10; turbo = 4'b0010; rx_ev = '1; tick(); idle();
    chk("R3 rx filter", sts_rd, 17'h04400);
    check_all("R3");

    // R4 transmit-empty filter: ch0 rx-only, ch3 reserved code
    sts_wr = 1; sts_wd = '1; tick(); idle();
    mode = 8'b11_00_00_01; turbo = '0; tx_ev = '1; tick(); idle();
    chk("R4 tx filter", sts_rd, 17'h01110);
    check_all("R4");

    // R6 event wins over same-cycle clear
    mode = '0; sts_wr = 1; sts_wd = '1; tx_ev = 4'b0010; tick(); idle();
    chk("R6 event beats clear", sts_rd, 17'h00010);

    // R11 sticky
    repeat (4) tick();
    chk("R11 sticky hold", sts_rd, 17'h00010);
    check_all("R11");

    // R8 fill: test-set first (no fill), then mode
    tb_wr = 1; tb_wd = 1; tick(); idle();
    chk("R8 no fill with mode clear", sts_rd, 17'h00010);
    tm_wr = 1; tm_wd = 1; tick(); idle();
    chk("R8 fill on mode entry", sts_rd, 17'h1777f);
    // R7 blocked clear
    sts_wr = 1; sts_wd = '1; tick(); idle();
    chk("R7 clear blocked", sts_rd, 17'h1777f);
    tb_wr = 1; tb_wd = 0; tick(); idle();
    sts_wr = 1; sts_wd = '1; tick(); idle();
    chk("R7 clear accepted after unlock", sts_rd, '0);
    tb_wr = 1; tb_wd = 1; tick(); idle();
    chk("R8 fill on test-set write", sts_rd, 17'h1777f);
    check_all("R8");

    // R10 soft reset overrides same-cycle writes and events
    soft_rst = 1; en_wr = 1; en_wd = '1; tx_ev = '1; tm_wr = 1; tm_wd = 1; tick(); idle();
    chk("R10 soft status", sts_rd, '0);
    chk("R10 soft enable", en_rd, '0);
    sts_wr = 1; sts_wd = '1; tx_ev = 4'b0001; tick(); idle();
    sts_wr = 1; sts_wd = '1; tick(); idle();
    chk("R10 test bits cleared by soft reset", sts_rd, '0);
    tick();
    check_all("R10");

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      soft_rst = ($urandom % 64) == 0;
      tx_ev  = $urandom; rx_ev = $urandom; turbo = $urandom; mode = $urandom;
      sts_wr = ($urandom % 4) == 0; sts_wd = $urandom;
      en_wr  = ($urandom % 8) == 0; en_wd = $urandom;
      tm_wr  = ($urandom % 32) == 0; tm_wd = $urandom;
      tb_wr  = ($urandom % 32) == 0; tb_wd = $urandom;
      tick();
      check_all("R11 R9 R1 random");
    end
    idle(); tick();
    check_all("R9 final");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule